// File: doc/BRIEF.md
# Latched Channel-Select Controller with Break-Before-Make

This block is the digital control side of a bus-attached analog multiplexer. A processor drives a binary channel number and an enable bit, then pulses an active-low write strobe. While the strobe is low, an internal latch follows those inputs. When the strobe returns high, the latch keeps what it last saw, so the switch setting survives until the next write. An active-low master clear empties the latch and opens every switch. A low enable opens every switch as well, which lets several such blocks share one analog output line.

The latched state is decoded into one-hot switch-drive lines. Whenever the selected channel changes, the block holds all drive lines low for a programmable number of sampling-clock cycles, so two sources are never joined. The parameter `DIFF` chooses between two layouts. With `DIFF` = 0 there are eight single-ended channels and a 3-bit address. With `DIFF` = 1 there are four differential pairs and a 2-bit address, and one select drives both legs of the chosen pair. The strobe and the clear are brought onto the sampling clock through two flip-flops each.

Top module: `chsel_ctrl`

## Requirements
- R1: While `wr_n` is low, the latch is transparent. A change of `addr` or `en` reaches the drive outputs without any further strobe edge.
- R2: While `wr_n` is high, the latch keeps the values it held when the strobe rose. Changes of `addr` or `en` leave the drive outputs unchanged.
- R3: While `clr_n` is low, both drive outputs are all-zero. This happens immediately, whatever the levels of `wr_n`, `en` and `addr`.
- R4: The clear also empties the latch. After `clr_n` rises with `wr_n` high, the outputs stay all-zero until a write loads `en` = 1.
- R5: A latched `en` of 0 turns every drive line off.
- R6: With `en` latched as 1, address value k drives bit k of `drv_a` (channel k+1) and no other bit. `drv_a` never has more than one bit set.
- R7: When the output changes from one channel straight to another, it is all-zero for exactly `BBM_CYCLES` cycles in between (`BBM_CYCLES` is at least 1). After any on period, at least `BBM_CYCLES` all-zero cycles pass before the next channel turns on, unless a clear intervenes.
- R8: Writing again the channel that is already on causes no change on the outputs and no off gap.
- R9: With `DIFF` = 1, only `addr[1:0]` is decoded, and `drv_b` equals `drv_a` (both legs of one pair). With `DIFF` = 0, `drv_b` is all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| clr_n | input | 1 | Active-low master clear; asserts asynchronously and releases through two flip-flops |
| wr_n | input | 1 | Active-low write strobe; the latch is open while it is low |
| addr | input | DIFF ? 2 : 3 | Binary channel number |
| en | input | 1 | Enable bit that is captured with the address |
| drv_a | output | DIFF ? 4 : 8 | One-hot switch drive (the a leg in differential mode) |
| drv_b | output | DIFF ? 4 : 8 | b-leg drive in differential mode; zero otherwise |

## Verification
The properties rely on two conditions at the inputs:
- `clr_n` is low at the first clock edge.
- `addr` and `en` are steady for a few cycles around each rise of `wr_n`. The strobe synchronizer lets the latch stay open for two to three cycles after the pin rises, so this hold time is needed.

The stimulus drives inputs a couple of nanoseconds after a rising edge. It keeps `addr` and `en` fixed for at least four cycles after each strobe release. It waits long enough after every change for the gap and the synchronizer latency to finish before the next change. With these waits, each expected output change can be queued in order and compared as it appears.

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
  parameter bit DIFF       = 1'b0,
  parameter int BBM_CYCLES = 2,
  localparam int NCH = DIFF ? 4 : 8,
  localparam int AW  = $clog2(NCH),
  localparam int GW  = $clog2(BBM_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic           en,
  output logic [NCH-1:0] drv_a,
  output logic [NCH-1:0] drv_b
);

  logic rs1, rs2, ws1, ws2;
  logic [AW-1:0] a_q, lat_addr, cur_ch;
  logic e_q, lat_en, cur_on;
  logic [GW-1:0] gap;
  logic [NCH-1:0] sel;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      {rs1, rs2, ws1, ws2} <= 4'b0011;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
      ws1 <= wr_n;
      ws2 <= ws1;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      a_q      <= '0;
      e_q      <= 1'b0;
      lat_addr <= '0;
      lat_en   <= 1'b0;
    end else begin
      a_q <= addr;
      e_q <= en;
      if (!rs2) begin
        lat_addr <= '0;
        lat_en   <= 1'b0;
      end else if (!ws2) begin
        lat_addr <= a_q;
        lat_en   <= e_q;
      end
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cur_on <= 1'b0;
      cur_ch <= '0;
      gap    <= '0;
    end else if (!rs2) begin
      cur_on <= 1'b0;
      cur_ch <= '0;
      gap    <= '0;
    end else if (cur_on) begin
      if (!lat_en || lat_addr != cur_ch) begin
        cur_on <= 1'b0;
        gap    <= GW'(BBM_CYCLES - 1);
      end
    end else if (gap != '0) begin
      gap <= gap - GW'(1);
    end else if (lat_en) begin
      cur_on <= 1'b1;
      cur_ch <= lat_addr;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign sel[i] = cur_on && (cur_ch == AW'(i));
  end

  assign drv_a = sel;

  if (DIFF) begin : g_pair
    assign drv_b = sel;
  end else begin : g_single
    assign drv_b = '0;
  end

endmodule

module chsel_ctrl_chk #(
  parameter int NCH        = 8,
  parameter int AW         = 3,
  parameter int BBM_CYCLES = 2
) (
  input logic           clk,
  input logic           clr_n,
  input logic           lat_en,
  input logic [AW-1:0]  lat_addr,
  input logic [NCH-1:0] drv_a,
  input logic [NCH-1:0] drv_b
);

  int   zcnt;
  logic had_on;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      zcnt   <= 0;
      had_on <= 1'b0;
    end else if (drv_a == '0) begin
      if (zcnt < 100000) zcnt <= zcnt + 1;
    end else begin
      zcnt   <= 0;
      had_on <= 1'b1;
    end
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot0(drv_a));

  p_bleg_onehot_r9: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot0(drv_b));

  p_clear_off_r3: assert property (@(posedge clk)
    !clr_n |-> (drv_a == '0 && drv_b == '0));

  p_disable_off_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !lat_en |=> drv_a == '0);

  p_no_cross_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (drv_a != '0 && $past(drv_a) != '0) |-> drv_a == $past(drv_a));

  p_min_gap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (drv_a != '0 && $past(drv_a) == '0 && had_on) |-> zcnt >= BBM_CYCLES);

  p_same_steady_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (lat_en && $stable(lat_en) && $stable(lat_addr) && drv_a != '0)
      |=> drv_a == $past(drv_a));

endmodule

bind chsel_ctrl chsel_ctrl_chk #(.NCH(NCH), .AW(AW), .BBM_CYCLES(BBM_CYCLES)) u_chk (
  .clk(clk), .clr_n(clr_n), .lat_en(lat_en), .lat_addr(lat_addr),
  .drv_a(drv_a), .drv_b(drv_b)
);

// File: tb/chsel_ctrl_tb.sv
module chsel_mon #(
  parameter int W = 16,
  parameter int B = 2
) (
  input logic         clk,
  input logic         clr_n,
  input logic [W-1:0] obs
);
  logic [W-1:0] qv[$];
  int           qg[$];
  string        qt[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] prev = '0;
  int zrun = 0;
  bit had_on = 0;

  task automatic push(input logic [W-1:0] v, input int g, input string t);
    qv.push_back(v);
    qg.push_back(g);
    qt.push_back(t);
  endtask

  task automatic drained(input string t);
    n_cmp++;
    if (qv.size() != 0) begin
      n_bad++;
      $display("FAIL %s: pending items actual %0d expected 0", t, qv.size());
    end
  endtask

  always @(negedge clk) begin
    if (!clr_n) begin
      had_on = 0;
      zrun = 0;
    end
    if (obs !== prev) begin
      n_cmp++;
      if (qv.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R8: unexpected output change actual %h expected %h", obs, prev);
      end else begin
        logic [W-1:0] v;
        int g;
        string t;
        v = qv.pop_front();
        g = qg.pop_front();
        t = qt.pop_front();
        if (obs !== v) begin
          n_bad++;
          $display("FAIL %s: output actual %h expected %h", t, obs, v);
        end else if (obs != '0 && g >= 0 && zrun != g) begin
          n_bad++;
          $display("FAIL %s R7: gap actual %0d expected %0d", t, zrun, g);
        end
      end
      if (obs != '0 && had_on) begin
        n_cmp++;
        if (zrun < B) begin
          n_bad++;
          $display("FAIL R7: minimum gap actual %0d expected >= %0d", zrun, B);
        end
      end
      prev = obs;
    end
    if (obs == '0) zrun++;
    else begin
      zrun = 0;
      had_on = 1;
    end
  end
endmodule

module chsel_ctrl_tb;
  localparam int BBM = 2;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic wr_n = 1'b1;
  logic en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] s_a, s_b;
  logic [3:0] d_a, d_b;

  int n_cmp = 0;
  int n_bad = 0;

  bit m_low = 0;
  bit m_rst = 0;
  logic [15:0] exp_s = '0;
  logic [7:0]  exp_d = '0;

  always #5 clk = ~clk;

  chsel_ctrl #(.DIFF(1'b0), .BBM_CYCLES(BBM)) u_dut (
    .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .addr(addr), .en(en),
    .drv_a(s_a), .drv_b(s_b)
  );

  chsel_ctrl #(.DIFF(1'b1), .BBM_CYCLES(BBM)) u_dif (
    .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .addr(addr[1:0]), .en(en),
    .drv_a(d_a), .drv_b(d_b)
  );

  chsel_mon #(.W(16), .B(BBM)) u_mon_s (.clk(clk), .clr_n(clr_n), .obs({s_b, s_a}));
  chsel_mon #(.W(8),  .B(BBM)) u_mon_d (.clk(clk), .clr_n(clr_n), .obs({d_b, d_a}));

  task automatic upd(input string tag);
    logic [15:0] ns;
    logic [7:0]  nd;
    ns = exp_s;
    nd = exp_d;
    if (m_rst) begin
      ns = '0;
      nd = '0;
    end else if (m_low) begin
      ns = en ? {8'h00, 8'(1 << addr)} : 16'h0;
      nd = en ? {4'(1 << addr[1:0]), 4'(1 << addr[1:0])} : 8'h0;
    end
    if (ns != exp_s) begin
      if (exp_s != '0 && ns != '0) begin
        u_mon_s.push('0, -1, tag);
        u_mon_s.push(ns, BBM, tag);
      end else u_mon_s.push(ns, -1, tag);
      exp_s = ns;
    end
    if (nd != exp_d) begin
      if (exp_d != '0 && nd != '0) begin
        u_mon_d.push('0, -1, {tag, " R9"});
        u_mon_d.push(nd, BBM, {tag, " R9"});
      end else u_mon_d.push(nd, -1, {tag, " R9"});
      exp_d = nd;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setin(input logic [2:0] a, input logic e, input string tag);
    addr = a;
    en = e;
    upd(tag);
  endtask

  task automatic wr_low(input string tag);
    wr_n = 1'b0;
    m_low = 1;
    upd(tag);
  endtask

  task automatic wr_high();
    wr_n = 1'b1;
    m_low = 0;
  endtask

  task automatic write(input logic [2:0] a, input logic e, input string tag);
    setin(a, e, tag);
    cyc(1);
    wr_low(tag);
    cyc(4);
    wr_high();
    cyc(BBM + 10);
  endtask

  task automatic clr_on(input string tag);
    clr_n = 1'b0;
    m_rst = 1;
    upd(tag);
  endtask

  task automatic clr_off(input string tag);
    clr_n = 1'b1;
    m_rst = 0;
    upd(tag);
  endtask

  task automatic check_now(input string tag);
    n_cmp++;
    if ({s_b, s_a} !== exp_s) begin
      n_bad++;
      $display("FAIL %s: single outputs actual %h expected %h", tag, {s_b, s_a}, exp_s);
    end
    n_cmp++;
    if ({d_b, d_a} !== exp_d) begin
      n_bad++;
      $display("FAIL %s R9: pair outputs actual %h expected %h", tag, {d_b, d_a}, exp_d);
    end
  endtask

  task automatic report();
    int tc, tb;
    tc = n_cmp + u_mon_s.n_cmp + u_mon_d.n_cmp;
    tb = n_bad + u_mon_s.n_bad + u_mon_d.n_bad;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", tc, tb);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run actual hung expected done");
    report();
  end

  initial begin
    #1;
    clr_on("R3");
    cyc(3);
    check_now("R3 reset state");
    setin(3'd5, 1'b1, "R3");
    wr_low("R3");
    cyc(5);
    check_now("R3 clear beats strobe");
    wr_high();
    cyc(5);
    clr_off("R4");
    cyc(12);
    check_now("R4 off after release");

    write(3'd0, 1'b1, "R6");
    check_now("R6 channel 1");
    for (int k = 1; k < 8; k++) begin
      write(3'(k), 1'b1, "R6 R7");
      check_now("R6 walk");
    end

    write(3'd7, 1'b1, "R8");
    check_now("R8 same channel");
    write(3'd3, 1'b1, "R8");
    check_now("R8 pair unchanged");

    setin(3'd1, 1'b1, "R2");
    cyc(6);
    setin(3'd4, 1'b0, "R2");
    cyc(20);
    check_now("R2 hold while high");

    write(3'd4, 1'b0, "R5");
    check_now("R5 disabled");
    write(3'd2, 1'b1, "R5 R7");
    check_now("R5 re-enabled");
    write(3'd2, 1'b0, "R5");
    write(3'd2, 1'b1, "R5 R7");
    check_now("R5 same channel after off");

    setin(3'd1, 1'b1, "R2");
    cyc(3);
    wr_low("R1");
    cyc(12);
    check_now("R1 open latch");
    setin(3'd6, 1'b1, "R1 R7");
    cyc(12);
    check_now("R1 follows address");
    setin(3'd6, 1'b0, "R1 R5");
    cyc(12);
    check_now("R1 follows enable");
    setin(3'd2, 1'b1, "R1");
    cyc(12);
    wr_high();
    cyc(8);
    check_now("R1 held after rise");

    clr_on("R3");
    cyc(1);
    check_now("R3 clear while on");
    cyc(3);
    clr_off("R4");
    cyc(12);
    check_now("R4 latch emptied");

    wr_low("R1");
    cyc(12);
    check_now("R1 on again");
    clr_on("R3");
    cyc(3);
    check_now("R3 clear with strobe low");
    clr_off("R1");
    cyc(14);
    check_now("R1 reopens after clear");
    wr_high();
    cyc(10);

    u_mon_s.drained("R6 single queue");
    u_mon_d.drained("R9 pair queue");
    report();
  end
endmodule